// File: doc/BRIEF.md
# Pulse-Group Waveform Sequencer

This block plays a stream of pulse groups on a single infrared-style output. Software writes 16-bit entries into an eight-deep queue. Each entry gives three things: how many PWM periods the group lasts, whether the carrier is on for the group, and which of two compare/max register pairs (primary or shadow) sets the period shape. The sequencer takes one entry at a time and runs the group on an internal period generator. As soon as a group ends it starts the next queued entry, so a long waveform can be built from many short entries with no gap between them.

Software keeps the queue topped up by watching a low-water interrupt. That interrupt is asserted while the fill level sits below a programmed threshold. A sticky group-done flag marks each completed group. An overflow flag records pushes that were lost because the queue was full. A flush input empties the queue without cutting short the group that is playing.

Top module: `pulse_seq`

## Requirements
- R1: `fifo_status` holds the fill count in bits 3:0, an empty flag in bit 4 and a full flag in bit 5. The queue holds up to DEPTH (8) entries, and a push is stored at the clock edge where `push` is high.
- R2: A push while the queue is full is dropped and sets the sticky `ovf` flag. `ovf_clr` clears the flag, but a new overflow in the same cycle wins.
- R3: `flush` empties the queue at the next edge and takes priority over a push in the same cycle. A group that is already playing runs to its end.
- R4: Entry bits 13:0 give the number of periods in the group, bit 14 selects the shadow pair when 1, and bit 15 turns the carrier on when 1.
- R5: One period lasts `max` cycles, or 1 cycle when `max` is 0. The output sits at the active level while the period phase is below `cmp`, and at the idle level for the rest of the period. When `pol` is 0 the active level is high and the idle level is low; `pol` = 1 swaps the two levels.
- R6: An entry with its carrier bit at 0 holds the output at the idle level for the full length of the group.
- R7: When the queue is not empty at the last cycle of a group, the next group starts on the following cycle with no idle cycle between.
- R8: An entry with a period count of 0 is removed and skipped, does not set `grp_sta`, and leaves the output idle for one cycle.
- R9: `grp_sta` becomes 1 after the last cycle of a group when `grp_ie` is 1, and stays 1 until `grp_clr` is pulsed. A new setting in the same cycle wins over the clear.
- R10: `lvl_irq` is 1 exactly when `lvl_ie` is 1 and the fill count is below `trig_level`.
- R11: While no group is playing, the output sits at the idle level.
- R12: The compare and max values are captured when an entry is taken. Changing the pair registers afterwards does not alter the group that is already playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Store `push_data` into the queue |
| push_data | input | 16 | Entry: carrier, shadow select, period count |
| flush | input | 1 | Empty the queue |
| pri_cmp | input | 16 | Primary active-segment length |
| pri_max | input | 16 | Primary period length |
| shd_cmp | input | 16 | Shadow active-segment length |
| shd_max | input | 16 | Shadow period length |
| pol | input | 1 | 1 = low level first |
| trig_level | input | 4 | Low-water threshold |
| lvl_ie | input | 1 | Enable for the low-water interrupt |
| grp_ie | input | 1 | Enable for the group-done flag |
| grp_clr | input | 1 | Clear `grp_sta` |
| ovf_clr | input | 1 | Clear `ovf` |
| pwm_out | output | 1 | Waveform output |
| fifo_status | output | 6 | {full, empty, fill[3:0]} |
| lvl_irq | output | 1 | Low-water interrupt |
| grp_sta | output | 1 | Sticky group-done flag |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A burst of long carrier-on entries fills the queue past its depth. This separates correct full detection and dropping from an off-by-one depth, and it checks that a flush leaves the playing group alone. Directed entries then mix the shadow pair, a carrier-off group and a zero-count entry. These show whether the pair select, idle holding and the one-cycle skip are each timed right. Random traffic with period lengths of 0 to 5 and compare values above and below the period length then runs against a cycle model in the bench. It also changes polarity, the pair registers and the thresholds at random. This traffic exposes wrong back-to-back handover, values taken after the entry starts, and low-water comparisons that are off by one.

// File: rtl/pulse_seq.sv
module pulse_seq #(
  parameter int DEPTH = 8,
  parameter int CW    = 16,
  parameter int NW    = 14,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [15:0]   push_data,
  input  logic          flush,
  input  logic [CW-1:0] pri_cmp,
  input  logic [CW-1:0] pri_max,
  input  logic [CW-1:0] shd_cmp,
  input  logic [CW-1:0] shd_max,
  input  logic          pol,
  input  logic [LW-1:0] trig_level,
  input  logic          lvl_ie,
  input  logic          grp_ie,
  input  logic          grp_clr,
  input  logic          ovf_clr,
  output logic          pwm_out,
  output logic [LW+1:0] fifo_status,
  output logic          lvl_irq,
  output logic          grp_sta,
  output logic          ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [LW-1:0] cnt;
  logic          busy, car;
  logic [CW-1:0] cur_cmp, cur_max, phase;
  logic [NW-1:0] rem;

  wire full  = cnt == LW'(DEPTH);
  wire empty = cnt == '0;
  wire wr    = push && !flush && !full;

  wire [CW-1:0] per_len  = (cur_max == '0) ? CW'(1) : cur_max;
  wire          last_ph  = phase == per_len - CW'(1);
  wire          grp_end  = busy && last_ph && rem == NW'(1);
  wire          take     = !flush && !empty && (!busy || grp_end);
  wire [15:0]   head     = mem[rptr];
  wire [NW-1:0] head_cnt = head[NW-1:0];

  always_ff @(posedge clk)
    if (wr) mem[wptr] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else begin
      if (take) rptr <= rptr + AW'(1);
      if (wr)   wptr <= wptr + AW'(1);
      cnt <= cnt + LW'(wr) - LW'(take);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      car     <= 1'b0;
      cur_cmp <= '0;
      cur_max <= '0;
      phase   <= '0;
      rem     <= '0;
    end else begin
      if (busy) begin
        if (last_ph) begin
          phase <= '0;
          rem   <= rem - NW'(1);
          if (rem == NW'(1)) busy <= 1'b0;
        end else begin
          phase <= phase + CW'(1);
        end
      end
      if (take && head_cnt != '0) begin
        busy    <= 1'b1;
        car     <= head[15];
        cur_cmp <= head[14] ? shd_cmp : pri_cmp;
        cur_max <= head[14] ? shd_max : pri_max;
        phase   <= '0;
        rem     <= head_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_sta <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (grp_end && grp_ie)     grp_sta <= 1'b1;
      else if (grp_clr)          grp_sta <= 1'b0;
      if (push && !flush && full) ovf    <= 1'b1;
      else if (ovf_clr)          ovf     <= 1'b0;
    end
  end

  assign pwm_out     = (busy && car && phase < cur_cmp) ? ~pol : pol;
  assign fifo_status = {full, empty, cnt};
  assign lvl_irq     = lvl_ie && (cnt < trig_level);
endmodule

module pulse_seq_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          flush,
  input logic          grp_clr,
  input logic          pol,
  input logic          lvl_ie,
  input logic          busy,
  input logic          pwm_out,
  input logic [LW+1:0] fifo_status,
  input logic          lvl_irq,
  input logic          grp_sta,
  input logic          ovf
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_status[LW] && fifo_status[LW+1])); // R1
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_status[LW-1:0] <= LW'(DEPTH)); // R1
  AST_OVF_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush && fifo_status[LW+1] |=> ovf); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fifo_status[LW]); // R3
  AST_GRP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    grp_sta && !grp_clr |=> grp_sta); // R9
  AST_LVL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_ie |-> !lvl_irq); // R10
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> pwm_out == pol); // R11
endmodule

bind pulse_seq pulse_seq_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .flush(flush), .grp_clr(grp_clr),
  .pol(pol), .lvl_ie(lvl_ie), .busy(busy), .pwm_out(pwm_out),
  .fifo_status(fifo_status), .lvl_irq(lvl_irq), .grp_sta(grp_sta), .ovf(ovf)
);

// File: tb/pulse_seq_bench.sv
`timescale 1ns/1ps
module pulse_seq_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, flush = 1'b0, pol = 1'b0;
  logic [15:0] push_data = '0;
  logic [15:0] pri_cmp = 16'd2, pri_max = 16'd4, shd_cmp = 16'd1, shd_max = 16'd3;
  logic [3:0]  trig_level = 4'd3;
  logic        lvl_ie = 1'b1, grp_ie = 1'b1, grp_clr = 1'b0, ovf_clr = 1'b0;
  logic        pwm_out, lvl_irq, grp_sta, ovf;
  logic [5:0]  fifo_status;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pulse_seq u_pulse_seq (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .flush(flush),
    .pri_cmp(pri_cmp), .pri_max(pri_max), .shd_cmp(shd_cmp), .shd_max(shd_max),
    .pol(pol), .trig_level(trig_level), .lvl_ie(lvl_ie), .grp_ie(grp_ie),
    .grp_clr(grp_clr), .ovf_clr(ovf_clr), .pwm_out(pwm_out),
    .fifo_status(fifo_status), .lvl_irq(lvl_irq), .grp_sta(grp_sta), .ovf(ovf)
  );

  logic [15:0] q[$];
  bit m_busy, m_car, m_grp, m_ovf;
  int m_cmp, m_max, m_phase, m_rem;

  always @(posedge clk) begin
    int len, sz0;
    bit last, tk;
    logic [15:0] h;
    if (!rst_n) begin
      q.delete();
      m_busy = 0; m_car = 0; m_grp = 0; m_ovf = 0;
      m_cmp = 0; m_max = 0; m_phase = 0; m_rem = 0;
    end else begin
      sz0  = q.size();
      len  = (m_max == 0) ? 1 : m_max;
      last = m_busy && m_phase == len - 1 && m_rem == 1;
      tk   = !flush && sz0 > 0 && (!m_busy || last);
      if (last && grp_ie) m_grp = 1; else if (grp_clr) m_grp = 0;
      if (push && !flush && sz0 == DEPTH) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (m_busy) begin
        if (m_phase == len - 1) begin
          m_phase = 0; m_rem--;
          if (m_rem == 0) m_busy = 0;
        end else m_phase++;
      end
      if (tk) begin
        h = q.pop_front();
        if (h[13:0] != 0) begin
          m_busy = 1; m_car = h[15]; m_phase = 0; m_rem = int'(h[13:0]);
          m_cmp = h[14] ? int'(shd_cmp) : int'(pri_cmp);
          m_max = h[14] ? int'(shd_max) : int'(pri_max);
        end
      end
      if (flush) q.delete();
      else if (push && sz0 < DEPTH) q.push_back(push_data);
    end
  end

  function automatic logic exp_out();
    return (m_busy && m_car && m_phase < m_cmp) ? ~pol : pol;
  endfunction

  function automatic logic [5:0] exp_status();
    int sz = q.size();
    return {sz == DEPTH, sz == 0, 4'(sz)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk("R4 R5 R6 R7 R8 R11 R12 pwm_out", 32'(pwm_out), 32'(exp_out()));
    chk("R1 R3 fifo_status", 32'(fifo_status), 32'(exp_status()));
    chk("R10 lvl_irq", 32'(lvl_irq), 32'(lvl_ie && q.size() < int'(trig_level)));
    chk("R9 grp_sta", 32'(grp_sta), 32'(m_grp));
    chk("R2 ovf", 32'(ovf), 32'(m_ovf));
  endtask

  task automatic push1(logic [15:0] d);
    push = 1'b1; push_data = d;
    cyc();
    push = 1'b0;
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk("R1 reset status empty", 32'(fifo_status), 32'h10);
    chk("R11 reset idle low", 32'(pwm_out), 32'd0);
    chk("R10 reset low-water", 32'(lvl_irq), 32'd1);
    chk("R9 reset grp_sta", 32'(grp_sta), 32'd0);

    for (int i = 0; i < 10; i++) push1(16'h8005);
    chk("R2 overflow flagged", 32'(ovf), 32'd1);
    chk("R1 full flag", 32'(fifo_status), 32'h28);
    ovf_clr = 1'b1; cyc(); ovf_clr = 1'b0;
    chk("R2 ovf cleared", 32'(ovf), 32'd0);
    flush = 1'b1; push = 1'b1; push_data = 16'h8001;
    cyc();
    flush = 1'b0; push = 1'b0;
    chk("R3 flush empties over push", 32'(fifo_status), 32'h10);
    for (int i = 0; i < 30; i++) cyc();
    chk("R11 idle after drain", 32'(pwm_out), 32'(pol));
    chk("R9 group done flag", 32'(grp_sta), 32'd1);
    grp_clr = 1'b1; cyc(); grp_clr = 1'b0;
    chk("R9 cleared", 32'(grp_sta), 32'd0);

    push1(16'hC002);
    push1(16'h8000);
    push1(16'h0002);
    pri_cmp = 16'd7; pri_max = 16'd2;
    push1(16'h8003);
    pri_cmp = 16'd0; pri_max = 16'd9;
    for (int i = 0; i < 30; i++) cyc();
    pol = 1'b1;
    push1(16'h8001);
    for (int i = 0; i < 10; i++) cyc();
    chk("R5 R11 inverted idle", 32'(pwm_out), 32'd1);

    for (int i = 0; i < 4000; i++) begin
      push = ($urandom_range(0, 9) < 4);
      push_data = {1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                   14'($urandom_range(0, 3))};
      flush   = ($urandom_range(0, 49) == 0);
      grp_clr = ($urandom_range(0, 9) == 0);
      ovf_clr = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 99) == 0) pol = ~pol;
      if ($urandom_range(0, 19) == 0) begin
        pri_cmp = 16'($urandom_range(0, 6)); pri_max = 16'($urandom_range(0, 5));
        shd_cmp = 16'($urandom_range(0, 6)); shd_max = 16'($urandom_range(0, 5));
      end
      if ($urandom_range(0, 29) == 0) begin
        trig_level = 4'($urandom_range(0, 9));
        lvl_ie = 1'($urandom_range(0, 1));
        grp_ie = ($urandom_range(0, 3) != 0);
      end
      cyc();
    end
    push = 1'b0; flush = 1'b0; grp_clr = 1'b0; ovf_clr = 1'b0;
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule